// File: doc/BRIEF.md
# SPI Channel Transfer Sequencer

This block holds the transfer state of one channel of a multichannel SPI master. It stores the channel's configuration word, its enable bit, the transmit and receive data words and three status flags (receive full, transmit empty, end of transfer). A register strobe interface writes and reads the data, configuration and control words. Every data access and every rising edge of the enable bit asks the block to consider one word exchange. The exchange is then started, held off, or, when the exchange port is not in use, completed internally.

The serial exchange is reached through a plain start/done port. The block raises `xfer_start` for one cycle and presents the word and its length. The serial engine later returns the received word with a one-cycle `xfer_done`. The status flags, two DMA request lines and two one-cycle event pulses for an interrupt block follow from the resulting state. A 2-bit mode field (full duplex, receive only, transmit only), a turbo bit and a force bit decide how the two data flags hold off transfers. With turbo set, a full receive word no longer blocks the next exchange.

Top module: `spi_chan_seq`

## Requirements
- R1: After reset the status is 3'b010 (bit 0 receive full = 0, bit 1 transmit empty = 1, bit 2 end of transfer = 0), the configuration reads 0x060000, the control word reads 0, and both DMA requests and `xfer_start` are low.
- R2: An attempt is evaluated only while the enable bit (control bit 0) is set. A control write with bit 0 = 1 while enable is 0 sets enable and requests an attempt. Any other control write loads bit 0 and requests nothing. With enable clear, data accesses start no exchange.
- R3: A write to the transmit register (select 0) stores the word, clears transmit empty in the next cycle and requests an attempt. When an exchange is launched, `xfer_start` is high for exactly one cycle, two cycles after the write cycle.
- R4: An attempt is held off while receive full is set, unless the mode field (configuration bits [13:12]) is 2 (transmit only) or turbo (configuration bit 19) is set.
- R5: An attempt is held off while transmit empty is set, unless the mode field is 1 (receive only).
- R6: A non-held attempt launches an exchange only when `single_mode` is low or force (configuration bit 20) is set. Otherwise the transfer completes in the evaluation cycle with no start, and the receive word is left unchanged.
- R7: At launch, `xfer_wlen` equals configuration bits [11:7] plus one, and `xfer_tx` equals the stored transmit word.
- R8: On completion, the received word is stored (exchange path only) and the transmit word becomes 0. End of transfer and transmit empty are set, and receive full is set unless the mode is 2. Mode 3 behaves as full duplex.
- R9: A read of the receive register (select 1) returns the stored word on `reg_rdata` in the same cycle, clears receive full in the next cycle and requests an attempt. Reads of other selects change nothing.
- R10: `dma_tx_req` = enable AND configuration bit 14 AND transmit empty AND mode not 1. `dma_rx_req` = enable AND configuration bit 15 AND receive full AND mode not 2.
- R11: `evt_rx_full` (receive full set, mode not 2, turbo clear) and `evt_tx_empty` (transmit empty set, mode not 1) pulse for one cycle. They are evaluated on the status after a held attempt or after a completion, and are visible in the cycle after that evaluation.
- R12: A configuration write (select 2) keeps bits [22:0] only. The control word (select 3) reads back as the enable bit alone.
- R13: End of transfer, once set, stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 2 | 0 transmit, 1 receive, 2 configuration, 3 control |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the selected register (combinational) |
| single_mode | input | 1 | Global single-channel mode flag |
| xfer_start | output | 1 | One-cycle exchange start |
| xfer_tx | output | DATA_W | Word to send, captured at launch |
| xfer_wlen | output | 6 | Word length in bits, captured at launch |
| xfer_done | input | 1 | Exchange finished (honoured only while one is in flight) |
| xfer_rx | input | DATA_W | Received word, valid with xfer_done |
| status | output | 3 | {end of transfer, transmit empty, receive full} |
| evt_rx_full | output | 1 | Receive-full event pulse |
| evt_tx_empty | output | 1 | Transmit-empty event pulse |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
A register access in cycle k changes the flags and the stored words at the edge that ends cycle k. The attempt it requests is evaluated in cycle k+1. A launched `xfer_start`, a held attempt's events and an internal completion's results are all visible from cycle k+2. An exchange completed by `xfer_done` in cycle d shows its status, data and events from cycle d+1. The DMA requests follow the visible state in the same cycle, and `reg_rdata` follows `reg_sel` combinationally. The bench advances a behavioural model at every rising edge from the same inputs. It compares every output half a cycle later, when inputs and registers are settled, so each result is checked in exactly the cycle it is due.

// File: rtl/spi_seq_pkg.sv
`timescale 1ns/1ps
package spi_seq_pkg;

    localparam int unsigned CFG_W       = 23;
    localparam int unsigned CFG_WL_LO   = 7;
    localparam int unsigned CFG_WL_W    = 5;
    localparam int unsigned CFG_MODE_LO = 12;
    localparam int unsigned CFG_DMA_TX  = 14;
    localparam int unsigned CFG_DMA_RX  = 15;
    localparam int unsigned CFG_TURBO   = 19;
    localparam int unsigned CFG_FORCE   = 20;
    localparam logic [CFG_W-1:0] CFG_RESET = 23'h060000;

    localparam int unsigned ST_RXF = 0;
    localparam int unsigned ST_TXE = 1;
    localparam int unsigned ST_EOT = 2;
    localparam int unsigned ST_W   = 3;
    localparam logic [ST_W-1:0] ST_RESET = 3'b010;

    typedef enum logic [1:0] {
        SEL_TX   = 2'd0,
        SEL_RX   = 2'd1,
        SEL_CONF = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        MODE_DUPLEX  = 2'd0,
        MODE_RX_ONLY = 2'd1,
        MODE_TX_ONLY = 2'd2,
        MODE_BAD     = 2'd3
    } xfer_mode_e;

endpackage

// File: rtl/spi_seq_gate.sv
`timescale 1ns/1ps
module spi_seq_gate
    import spi_seq_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       turbo,
    input  logic       rx_full,
    input  logic       tx_empty,
    output logic       rx_cond,
    output logic       tx_cond
);

    // A full receive word matters unless the channel only transmits or
    // turbo lets one more word be exchanged ahead of the read.
    always_comb begin
        rx_cond = rx_full && (mode != MODE_TX_ONLY) && !turbo;
        tx_cond = tx_empty && (mode != MODE_RX_ONLY);
    end

endmodule

// File: rtl/spi_seq_dma.sv
`timescale 1ns/1ps
module spi_seq_dma
    import spi_seq_pkg::*;
(
    input  logic       en,
    input  logic       tx_dma_on,
    input  logic       rx_dma_on,
    input  logic [1:0] mode,
    input  logic       rx_full,
    input  logic       tx_empty,
    output logic       dma_tx,
    output logic       dma_rx
);

    always_comb begin
        dma_tx = en && tx_dma_on && tx_empty && (mode != MODE_RX_ONLY);
        dma_rx = en && rx_dma_on && rx_full  && (mode != MODE_TX_ONLY);
    end

endmodule

// File: rtl/spi_seq_rdmux.sv
`timescale 1ns/1ps
module spi_seq_rdmux
    import spi_seq_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] tx_word,
    input  logic [DATA_W-1:0] rx_word,
    input  logic [CFG_W-1:0]  conf,
    input  logic              en,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        unique case (reg_sel_e'(sel))
            SEL_TX:   rdata = tx_word;
            SEL_RX:   rdata = rx_word;
            SEL_CONF: rdata = DATA_W'(conf);
            default:  rdata = DATA_W'(en);
        endcase
    end

endmodule

// File: rtl/spi_chan_seq.sv
`timescale 1ns/1ps
module spi_chan_seq
    import spi_seq_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              single_mode,
    output logic              xfer_start,
    output logic [DATA_W-1:0] xfer_tx,
    output logic [5:0]        xfer_wlen,
    input  logic              xfer_done,
    input  logic [DATA_W-1:0] xfer_rx,
    output logic [2:0]        status,
    output logic              evt_rx_full,
    output logic              evt_tx_empty,
    output logic              dma_tx_req,
    output logic              dma_rx_req
);

    localparam int unsigned WLEN_W = CFG_WL_W + 1;

    typedef struct packed {
        logic [CFG_W-1:0]  conf;
        logic              en;
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
        logic [ST_W-1:0]   stat;
        logic              busy;
        logic              pend;
        logic              start;
        logic [DATA_W-1:0] xtx;
        logic [WLEN_W-1:0] xwl;
        logic              ev_rx;
        logic              ev_tx;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic [1:0]        mode;
    logic              turbo;
    logic              force_x;
    logic [WLEN_W-1:0] wl_now;
    logic [ST_W-1:0]   stat_cmp;
    logic              cur_rx, cur_tx;
    logic              cmp_rx, cmp_tx;

    assign mode    = st_q.conf[CFG_MODE_LO +: 2];
    assign turbo   = st_q.conf[CFG_TURBO];
    assign force_x = st_q.conf[CFG_FORCE];
    assign wl_now  = WLEN_W'(st_q.conf[CFG_WL_LO +: CFG_WL_W]) + WLEN_W'(1);

    // Status as it stands once a word exchange has finished.
    always_comb begin
        stat_cmp         = st_q.stat;
        stat_cmp[ST_EOT] = 1'b1;
        stat_cmp[ST_TXE] = 1'b1;
        if (mode != MODE_TX_ONLY) begin
            stat_cmp[ST_RXF] = 1'b1;
        end
    end

    // Hold-off and event conditions on the present status.
    spi_seq_gate u_gate_cur (
        .mode     (mode),
        .turbo    (turbo),
        .rx_full  (st_q.stat[ST_RXF]),
        .tx_empty (st_q.stat[ST_TXE]),
        .rx_cond  (cur_rx),
        .tx_cond  (cur_tx)
    );

    // Event conditions on the post-completion status.
    spi_seq_gate u_gate_cmp (
        .mode     (mode),
        .turbo    (turbo),
        .rx_full  (stat_cmp[ST_RXF]),
        .tx_empty (stat_cmp[ST_TXE]),
        .rx_cond  (cmp_rx),
        .tx_cond  (cmp_tx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        st_d.ev_rx = 1'b0;
        st_d.ev_tx = 1'b0;

        // Transfer side: finish an exchange in flight, or evaluate a
        // pending attempt when none is in flight.
        if (st_q.busy && xfer_done) begin
            st_d.rx    = xfer_rx;
            st_d.tx    = '0;
            st_d.stat  = stat_cmp;
            st_d.busy  = 1'b0;
            st_d.ev_rx = cmp_rx;
            st_d.ev_tx = cmp_tx;
        end else if (st_q.pend && !st_q.busy) begin
            st_d.pend = 1'b0;
            if (st_q.en) begin
                if (cur_rx || cur_tx) begin
                    st_d.ev_rx = cur_rx;
                    st_d.ev_tx = cur_tx;
                end else if (!single_mode || force_x) begin
                    st_d.start = 1'b1;
                    st_d.busy  = 1'b1;
                    st_d.xtx   = st_q.tx;
                    st_d.xwl   = wl_now;
                end else begin
                    st_d.tx    = '0;
                    st_d.stat  = stat_cmp;
                    st_d.ev_rx = cmp_rx;
                    st_d.ev_tx = cmp_tx;
                end
            end
        end

        // Register side: applied after the transfer side, so an access
        // in the same cycle has the last word on what it touches.
        if (reg_wr) begin
            unique case (reg_sel_e'(reg_sel))
                SEL_TX: begin
                    st_d.tx           = reg_wdata;
                    st_d.stat[ST_TXE] = 1'b0;
                    st_d.pend         = 1'b1;
                end
                SEL_CONF: begin
                    st_d.conf = reg_wdata[CFG_W-1:0];
                end
                SEL_CTRL: begin
                    if (reg_wdata[0] && !st_q.en) begin
                        st_d.en   = 1'b1;
                        st_d.pend = 1'b1;
                    end else begin
                        st_d.en = reg_wdata[0];
                    end
                end
                default: begin
                end
            endcase
        end
        if (reg_rd && (reg_sel == SEL_RX)) begin
            st_d.stat[ST_RXF] = 1'b0;
            st_d.pend         = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.conf <= CFG_RESET;
            st_q.stat <= ST_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    spi_seq_dma u_dma (
        .en        (st_q.en),
        .tx_dma_on (st_q.conf[CFG_DMA_TX]),
        .rx_dma_on (st_q.conf[CFG_DMA_RX]),
        .mode      (mode),
        .rx_full   (st_q.stat[ST_RXF]),
        .tx_empty  (st_q.stat[ST_TXE]),
        .dma_tx    (dma_tx_req),
        .dma_rx    (dma_rx_req)
    );

    spi_seq_rdmux #(.DATA_W(DATA_W)) u_rdmux (
        .sel     (reg_sel),
        .tx_word (st_q.tx),
        .rx_word (st_q.rx),
        .conf    (st_q.conf),
        .en      (st_q.en),
        .rdata   (reg_rdata)
    );

    assign xfer_start   = st_q.start;
    assign xfer_tx      = st_q.xtx;
    assign xfer_wlen    = st_q.xwl;
    assign status       = st_q.stat;
    assign evt_rx_full  = st_q.ev_rx;
    assign evt_tx_empty = st_q.ev_tx;

endmodule

// File: rtl/spi_seq_chk.sv
`timescale 1ns/1ps
module spi_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic [1:0] reg_sel,
    input logic       xfer_start,
    input logic       xfer_done,
    input logic [2:0] status,
    input logic       dma_tx_req,
    input logic       dma_rx_req
);

    p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);

    p_tx_write_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd0) |=> !status[1]);

    p_rx_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_sel == 2'd1 && !xfer_done) |=> !status[0]);

    p_dma_tx_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dma_tx_req |-> status[1]);

    p_dma_rx_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rx_req |-> status[0]);

    p_eot_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
        status[2] |=> status[2]);

endmodule

bind spi_chan_seq spi_seq_chk u_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_sel    (reg_sel),
    .xfer_start (xfer_start),
    .xfer_done  (xfer_done),
    .status     (status),
    .dma_tx_req (dma_tx_req),
    .dma_rx_req (dma_rx_req)
);

// File: tb/tb_spi_chan_seq.sv
`timescale 1ns/1ps
module tb_spi_chan_seq;

    localparam int DW = 32;
    localparam logic [31:0] RX_MIX = 32'hA5A50000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [1:0]    reg_sel = 2'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          single_mode = 1'b0;
    logic          xfer_start;
    logic [DW-1:0] xfer_tx;
    logic [5:0]    xfer_wlen;
    logic          xfer_done = 1'b0;
    logic [DW-1:0] xfer_rx = '0;
    logic [2:0]    status;
    logic          evt_rx_full, evt_tx_empty, dma_tx_req, dma_rx_req;

    int total = 0;
    int bad = 0;
    int n_starts = 0;
    int pcnt = 0;
    int cycles = 0;
    logic [31:0] cap_tx;
    logic [5:0]  cap_wl;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    spi_chan_seq #(.DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .single_mode(single_mode), .xfer_start(xfer_start), .xfer_tx(xfer_tx),
        .xfer_wlen(xfer_wlen), .xfer_done(xfer_done), .xfer_rx(xfer_rx),
        .status(status), .evt_rx_full(evt_rx_full), .evt_tx_empty(evt_tx_empty),
        .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [22:0] m_conf;
    logic        m_en, m_rxf, m_txe, m_eot, m_busy, m_pend;
    logic        m_start, m_evr, m_evt;
    logic [31:0] m_tx, m_rx, m_xtx;
    logic [5:0]  m_xwl;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_conf = 23'h060000; m_en = 0; m_rxf = 0; m_txe = 1; m_eot = 0;
            m_busy = 0; m_pend = 0; m_start = 0; m_evr = 0; m_evt = 0;
            m_tx = 0; m_rx = 0; m_xtx = 0; m_xwl = 0;
        end else begin
            int md;
            bit tb, fc, hold_r, hold_t, fin;
            md = int'(m_conf[13:12]); tb = m_conf[19]; fc = m_conf[20];
            hold_r = m_rxf && md != 2 && !tb;
            hold_t = m_txe && md != 1;
            fin = 0;
            m_start = 0; m_evr = 0; m_evt = 0;
            if (m_busy && xfer_done) begin
                m_rx = xfer_rx; m_busy = 0; fin = 1;
            end else if (m_pend && !m_busy) begin
                m_pend = 0;
                if (m_en) begin
                    if (hold_r || hold_t) begin
                        m_evr = hold_r; m_evt = hold_t;
                    end else if (!single_mode || fc) begin
                        m_start = 1; m_busy = 1; m_xtx = m_tx;
                        m_xwl = 6'(m_conf[11:7]) + 6'd1;
                    end else begin
                        fin = 1;
                    end
                end
            end
            if (fin) begin
                m_tx = 0; m_eot = 1; m_txe = 1;
                if (md != 2) m_rxf = 1;
                m_evr = m_rxf && md != 2 && !tb;
                m_evt = (md != 1);
            end
            if (reg_wr) begin
                case (reg_sel)
                    2'd0: begin m_tx = reg_wdata; m_txe = 0; m_pend = 1; end
                    2'd2: m_conf = reg_wdata[22:0];
                    2'd3: begin
                        if (reg_wdata[0] && !m_en) begin m_en = 1; m_pend = 1; end
                        else m_en = reg_wdata[0];
                    end
                    default: ;
                endcase
            end
            if (reg_rd && reg_sel == 2'd1) begin m_rxf = 0; m_pend = 1; end
        end
    end

    // per-cycle comparison, half a cycle after the edge
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            logic [31:0] exp_rd;
            int md;
            md = int'(m_conf[13:12]);
            chk("R8 status", 32'(status), 32'({m_eot, m_txe, m_rxf}));
            chk("R3 xfer_start", 32'(xfer_start), 32'(m_start));
            chk("R11 evt_rx_full", 32'(evt_rx_full), 32'(m_evr));
            chk("R11 evt_tx_empty", 32'(evt_tx_empty), 32'(m_evt));
            chk("R10 dma_tx_req", 32'(dma_tx_req), 32'(m_en && m_conf[14] && m_txe && md != 1));
            chk("R10 dma_rx_req", 32'(dma_rx_req), 32'(m_en && m_conf[15] && m_rxf && md != 2));
            case (reg_sel)
                2'd0: exp_rd = m_tx;
                2'd1: exp_rd = m_rx;
                2'd2: exp_rd = 32'(m_conf);
                default: exp_rd = 32'(m_en);
            endcase
            chk("R9 reg_rdata", reg_rdata, exp_rd);
            if (xfer_start) begin
                chk("R7 xfer_wlen", 32'(xfer_wlen), 32'(m_xwl));
                chk("R7 xfer_tx", xfer_tx, m_xtx);
            end
        end
    end

    // serial engine stand-in: done three cycles after start
    always @(negedge clk) begin
        xfer_done = 1'b0;
        if (pcnt == 1) begin
            xfer_done = 1'b1;
            xfer_rx = cap_tx ^ RX_MIX ^ 32'(cap_wl);
        end
        if (pcnt > 0) pcnt--;
        if (rst_n && xfer_start) begin
            pcnt = 3; cap_tx = xfer_tx; cap_wl = xfer_wlen; n_starts++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] d);
        @(negedge clk);
        reg_rd = (s == 2'd1); reg_sel = s;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(3);
        // R1 reset state
        chk("R1 status", 32'(status), 32'h2);
        chk("R1 dma", 32'({dma_tx_req, dma_rx_req}), 32'h0);
        rd(2'd2, rv); chk("R1 conf", rv, 32'h060000);
        rd(2'd3, rv); chk("R1 ctrl", rv, 32'h0);

        // length 8, full duplex, both DMA enables
        wr(2'd2, 32'h0000C380);
        wr(2'd0, 32'h11);
        idle(5);
        chk("R2 no start while disabled", 32'(n_starts), 32'd0);
        wr(2'd3, 32'h1);
        idle(8);
        chk("R2 enable launches", 32'(n_starts), 32'd1);
        chk("R8 status after exchange", 32'(status), 32'h7);
        rd(2'd1, rv); chk("R9 rx word", rv, 32'hA5A50019);
        idle(3);
        chk("R5 held by tx empty", 32'(status), 32'h6);

        // R4 receive full holds off the next word
        wr(2'd0, 32'h22); idle(8);
        wr(2'd0, 32'h33); idle(8);
        chk("R4 held by rx full", 32'(n_starts), 32'd2);
        rd(2'd1, rv); chk("R9 rx word 2", rv, 32'hA5A5002A);
        idle(8);
        chk("R4 released by read", 32'(n_starts), 32'd3);
        rd(2'd1, rv); chk("R9 rx word 3", rv, 32'hA5A5003B);
        idle(4);

        // turbo lets a word go while receive is full
        wr(2'd2, 32'h0008C380);
        wr(2'd0, 32'h44); idle(8);
        wr(2'd0, 32'h55); idle(8);
        chk("R4 turbo ignores rx full", 32'(n_starts), 32'd5);

        // transmit only leaves receive full clear
        wr(2'd2, 32'h0000E380);
        rd(2'd1, rv);
        wr(2'd0, 32'h66); idle(8);
        chk("R8 tx-only status", 32'(status), 32'h6);
        chk("R8 tx-only launched", 32'(n_starts), 32'd6);

        // receive only runs with transmit empty
        wr(2'd2, 32'h0000D380);
        rd(2'd1, rv); idle(8);
        chk("R5 rx-only ignores tx empty", 32'(n_starts), 32'd7);
        chk("R5 rx-only status", 32'(status), 32'h7);
        rd(2'd1, rv); chk("R9 rx-only word", rv, 32'hA5A50008);
        idle(8);

        // single mode: internal completion unless forced
        single_mode = 1'b1;
        wr(2'd2, 32'h0000C380);
        rd(2'd1, rv); idle(3);
        wr(2'd0, 32'h77); idle(4);
        chk("R6 no start in single mode", 32'(n_starts), 32'd8);
        chk("R6 status after internal completion", 32'(status), 32'h7);
        rd(2'd1, rv); chk("R6 rx unchanged", rv, 32'hA5A50008);
        idle(3);
        wr(2'd2, 32'h0010C380);
        wr(2'd0, 32'h88); idle(8);
        chk("R6 force launches", 32'(n_starts), 32'd9);
        rd(2'd1, rv); chk("R6 forced rx word", rv, 32'hA5A50080);
        single_mode = 1'b0;

        // R7 longest word, mode 3 as full duplex (R8)
        wr(2'd2, 32'h00003F80);
        idle(3);
        wr(2'd0, 32'h99); idle(8);
        chk("R8 mode 3 sets rx full", 32'(status[0]), 32'd1);
        rd(2'd1, rv); chk("R7 length 32 word", rv, 32'hA5A500B9);
        idle(3);

        // R12 config mask, R2 disable, R13 sticky end of transfer
        wr(2'd3, 32'h0);
        wr(2'd2, 32'hFFFFFFFF);
        rd(2'd2, rv); chk("R12 conf mask", rv, 32'h007FFFFF);
        rd(2'd3, rv); chk("R12 ctrl readback", rv, 32'h0);
        wr(2'd0, 32'hAA); idle(5);
        chk("R2 disabled no start", 32'(n_starts), 32'd10);
        chk("R13 eot sticky", 32'(status[2]), 32'd1);

        idle(4);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule